// File: doc/BRIEF.md
# Register-Configurable UART Port

This block is a single asynchronous serial port that a host controls through a small parallel register port. Every access is one clock with `reg_valid` high and a 2-bit operation code on `reg_mode`. There are four operations. A configuration write sets the framing: a baud select, a data length and a parity option. A data write queues one byte for transmission. A data read takes the oldest received byte, together with its error flags. A status read returns the FIFO and line flags.

The port holds an 8-entry transmit FIFO and an 8-entry receive FIFO. It also has a transmit serializer and a 16x-oversampled receiver that share one tick generator. Two hardware handshake pins pace the link: `rts_o` tells the far end whether the receive FIFO can take data, and `cts_i` tells the transmitter whether it may start a frame. Read results appear on `reg_rdata` one clock after the access and stay there until the next read.

Top module: `cfg_uart`

## Requirements
- R1: A configuration write (mode 11) latches `reg_wdata[6:0]` as the framing word and applies it to both directions. The fields are baud select in bits 2..0, length code in bits 4..3, parity enable in bit 5 and parity type in bit 6. After reset the word is zero: select 0, 5 data bits, no parity.
- R2: One bit on the line lasts 16 ticks. One tick lasts `TICK_BASE << sel` clocks. The first bit of a frame may be shortened by up to one tick period, so a start bit is longer than 15 tick periods and no longer than 16.
- R3: A frame is a low start bit, then N = 5 + length code data bits sent LSB first, then a parity bit if parity is enabled, then one high stop bit. Parity type 0 is even (the bit equals the XOR of the data bits) and type 1 is odd. A received byte is right-aligned, with the unused upper bits zero.
- R4: A data write (mode 10) pushes `reg_wdata[7:0]` into the transmit FIFO. A write to a full FIFO is dropped.
- R5: A data read (mode 01) pops the receive FIFO. One clock later it returns {0, parity error, break error, byte} in bits 10, 9, 8 and 7..0. A read of an empty FIFO returns zero.
- R6: A received frame whose parity bit does not match the parity type is stored with bit 9 set.
- R7: A received frame in which the data bits, the parity bit (when enabled) and the stop bit are all low is stored with bit 8 set. The receiver does not start again until the line has gone high and then low again.
- R8: A status read (mode 00) returns, one clock later: receive-full in bit 0, transmit-full in bit 1, transmitter busy in bit 2, receiver busy in bit 3, `rts_o` in bit 4, synchronized `cts_i` in bit 5, and zero in bits 10..6.
- R9: `rts_o` is low exactly when the receive FIFO holds 8 entries. Once the receive FIFO is full, further received frames are dropped.
- R10: No new frame starts while the synchronized `cts_i` is low. Queued bytes wait in the FIFO.
- R11: `txd` is high from reset and whenever no frame is being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | One-clock access strobe |
| reg_mode | input | 2 | Operation code: 00 status, 01 data read, 10 data write, 11 config write |
| reg_wdata | input | 8 | Write data: byte for mode 10, framing word in bits 6..0 for mode 11 |
| reg_rdata | output | 11 | Result of the last read access |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rts_o | output | 1 | High while the receive FIFO can accept a byte |
| cts_i | input | 1 | High when the far end allows transmission |

## Verification
The hardest situations to reach from the ports are a full receive FIFO with `rts_o` low, and a frame whose parity bit is wrong or that is held low for its whole length. A looped-back transmitter can produce neither. To fill the FIFO, the bench holds `cts_i` low while it overfills the transmit FIFO, then releases `cts_i` so that eight frames arrive back to back. For the error cases the bench disconnects the loopback and drives `rxd` itself with hand-built frames: one with an inverted parity bit, and one that stays low for a full frame. Randomized loopback frames over all lengths, parities and two baud selects exercise the normal framing path.

// File: rtl/cfg_uart_pkg.sv
package cfg_uart_pkg;

   localparam int RD_W   = 11;
   localparam int WR_W   = 8;
   localparam int RXW_W  = 10;
   localparam int FRM_W  = 12;

   typedef enum logic [1:0] {
      OP_STAT = 2'b00,
      OP_READ = 2'b01,
      OP_SEND = 2'b10,
      OP_CONF = 2'b11
   } op_e;

   typedef struct packed {
      logic       ptype;
      logic       pen;
      logic [1:0] len;
      logic [2:0] sel;
   } frame_cfg_t;

   function automatic logic [3:0] data_bits(input logic [1:0] len);
      return 4'd5 + {2'b00, len};
   endfunction

   function automatic logic [7:0] len_mask(input logic [1:0] len);
      return 8'hFF >> (4'd3 - {2'b00, len});
   endfunction

   function automatic logic [FRM_W-1:0] build_frame(input logic [7:0] d, input logic [1:0] len,
                                                     input logic pen, input logic ptype);
      logic [FRM_W-1:0] f;
      logic [7:0]       m;
      logic [3:0]       n;
      n = data_bits(len);
      m = d & len_mask(len);
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < int'(n)) f[i+1] = m[i];
      end
      if (pen) f[n + 4'd1] = (^m) ^ ptype;
      return f;
   endfunction

endpackage

// File: rtl/cfg_uart_fifo.sv
module cfg_uart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         do_push, do_pop;

   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign empty   = (wp == rp);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[AW-1:0]] <= din;
   end
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
   import cfg_uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] len,
   input  logic       pen,
   input  logic       ptype,
   input  logic       avail,
   input  logic       cts,
   input  logic [7:0] data,
   output logic       load,
   output logic       txd,
   output logic       busy
);
   logic [FRM_W-1:0] sh;
   logic [3:0]       left;
   logic [3:0]       tcnt;

   assign load = !busy && avail && cts;
   assign txd  = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         tcnt <= '0;
         busy <= 1'b0;
      end else if (!busy) begin
         if (load) begin
            busy <= 1'b1;
            sh   <= build_frame(data, len, pen, ptype);
            left <= data_bits(len) + 4'd2 + {3'b000, pen};
            tcnt <= '0;
         end
      end else if (tick) begin
         if (tcnt == 4'd15) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[FRM_W-1:1]};
            left <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 4'd1;
         end
      end
   end
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
   import cfg_uart_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       len,
   input  logic             pen,
   input  logic             ptype,
   input  logic             rxd,
   output logic             push,
   output logic [RXW_W-1:0] word,
   output logic             busy
);
   logic [SYNC_STAGES-1:0] sy;
   logic                   prev;
   logic                   rx_s;
   logic                   fall;
   logic [3:0]             tcnt, bitpos, last, nb;
   logic [FRM_W-1:0]       rsh;
   logic [7:0]             dat;
   logic                   par, perr, brk;

   assign rx_s = sy[SYNC_STAGES-1];
   assign fall = prev && !rx_s;
   assign nb   = data_bits(len);
   assign last = nb + 4'd1 + {3'b000, pen};

   always_comb begin
      for (int i = 0; i < 8; i++) dat[i] = (i < int'(nb)) ? rsh[i+1] : 1'b0;
      par  = rsh[nb + 4'd1];
      perr = pen && (par != ((^dat) ^ ptype));
      brk  = (dat == 8'h00) && !(pen && par) && !rx_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy   <= '1;
         prev <= 1'b1;
      end else begin
         sy   <= {sy[SYNC_STAGES-2:0], rxd};
         prev <= rx_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tcnt   <= '0;
         bitpos <= '0;
         rsh    <= '0;
         push   <= 1'b0;
         word   <= '0;
      end else begin
         push <= 1'b0;
         if (!busy) begin
            if (fall) begin
               busy   <= 1'b1;
               tcnt   <= '0;
               bitpos <= '0;
            end
         end else if (tick) begin
            if (bitpos == 4'd0) begin
               if (tcnt == 4'd7) begin
                  if (rx_s) busy <= 1'b0;
                  else begin
                     bitpos <= 4'd1;
                     tcnt   <= '0;
                  end
               end else tcnt <= tcnt + 4'd1;
            end else if (tcnt == 4'd15) begin
               tcnt        <= '0;
               rsh[bitpos] <= rx_s;
               if (bitpos == last) begin
                  busy <= 1'b0;
                  push <= 1'b1;
                  word <= {perr, brk, dat};
               end else bitpos <= bitpos + 4'd1;
            end else tcnt <= tcnt + 4'd1;
         end
      end
   end
endmodule

// File: rtl/cfg_uart.sv
module cfg_uart
   import cfg_uart_pkg::*;
#(
   parameter int FIFO_DEPTH  = 8,
   parameter int TICK_BASE   = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_valid,
   input  logic [1:0]      reg_mode,
   input  logic [WR_W-1:0] reg_wdata,
   output logic [RD_W-1:0] reg_rdata,
   output logic            txd,
   input  logic            rxd,
   output logic            rts_o,
   input  logic            cts_i
);
   localparam int DW = $clog2(TICK_BASE + 1) + 8;

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cfg_uart: FIFO_DEPTH must be a power of two of at least 2");
   end
   if (TICK_BASE < 1) begin : g_bad_tick
      $error("cfg_uart: TICK_BASE must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_uart: SYNC_STAGES must be at least 2");
   end

   frame_cfg_t             cfg;
   logic [DW-1:0]          dcnt, div;
   logic                   tick;
   logic [SYNC_STAGES-1:0] cts_sy;
   logic                   cts_s;
   logic                   tx_push, tx_load, tx_full, tx_empty, tx_busy;
   logic [7:0]             tx_dout;
   logic                   rx_push, rx_pop, rx_full, rx_empty, rx_busy;
   logic [RXW_W-1:0]       rx_word, rx_dout;

   assign div     = DW'(TICK_BASE) << cfg.sel;
   assign tick    = (dcnt >= div - 1'b1);
   assign cts_s   = cts_sy[SYNC_STAGES-1];
   assign rts_o   = !rx_full;
   assign tx_push = reg_valid && (op_e'(reg_mode) == OP_SEND);
   assign rx_pop  = reg_valid && (op_e'(reg_mode) == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt   <= '0;
         cts_sy <= '0;
      end else begin
         dcnt   <= tick ? '0 : dcnt + 1'b1;
         cts_sy <= {cts_sy[SYNC_STAGES-2:0], cts_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         reg_rdata <= '0;
      end else if (reg_valid) begin
         case (op_e'(reg_mode))
            OP_STAT: reg_rdata <= {5'b0, cts_s, rts_o, rx_busy, tx_busy, tx_full, rx_full};
            OP_READ: reg_rdata <= rx_empty ? '0 : {1'b0, rx_dout};
            OP_CONF: cfg       <= frame_cfg_t'(reg_wdata[6:0]);
            default: ;
         endcase
      end
   end

   cfg_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata),
      .pop(tx_load), .dout(tx_dout), .full(tx_full), .empty(tx_empty)
   );

   cfg_uart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .len(cfg.len), .pen(cfg.pen),
      .ptype(cfg.ptype), .avail(!tx_empty), .cts(cts_s), .data(tx_dout),
      .load(tx_load), .txd(txd), .busy(tx_busy)
   );

   cfg_uart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .len(cfg.len), .pen(cfg.pen),
      .ptype(cfg.ptype), .rxd(rxd), .push(rx_push), .word(rx_word), .busy(rx_busy)
   );

   cfg_uart_fifo #(.W(RXW_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
      .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty)
   );
endmodule

// File: rtl/cfg_uart_chk.sv
module cfg_uart_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_valid,
   input logic [1:0]  reg_mode,
   input logic [10:0] reg_rdata,
   input logic        txd,
   input logic        rts_o,
   input logic        tx_busy,
   input logic        cts_s,
   input logic        rx_empty,
   input logic        rx_full
);
   // R11
   txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   // R10
   cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && !cts_s) |=> !tx_busy);

   // R5
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_mode == 2'b01 && rx_empty) |=> (reg_rdata == 11'd0));

   // R8
   status_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_mode == 2'b00) |=> (reg_rdata[4] == $past(rts_o) && reg_rdata[10:6] == 5'd0));

   // R9
   rts_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !rts_o);
endmodule

bind cfg_uart cfg_uart_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_mode(reg_mode),
   .reg_rdata(reg_rdata), .txd(txd), .rts_o(rts_o), .tx_busy(tx_busy),
   .cts_s(cts_s), .rx_empty(rx_empty), .rx_full(rx_full)
);

// File: tb/cfg_uart_bench.sv
`timescale 1ns/1ps
module cfg_uart_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic [1:0]  reg_mode = 2'b00;
   logic [7:0]  reg_wdata = 8'h00;
   logic [10:0] reg_rdata;
   logic        txd, rxd, rts_o;
   logic        cts_i = 1'b1;
   logic        loop_en = 1'b1;
   logic        bench_rx = 1'b1;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;
   assign rxd = loop_en ? txd : bench_rx;

   cfg_uart u_cfg_uart (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_mode(reg_mode),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd), .rxd(rxd),
      .rts_o(rts_o), .cts_i(cts_i)
   );

   function automatic logic [7:0] mask_of(input int len);
      return 8'hFF >> (3 - len);
   endfunction

   function automatic logic [10:0] exp_read(input logic perr, input logic brk, input logic [7:0] d, input int len);
      return {1'b0, perr, brk, d & mask_of(len)};
   endfunction

   function automatic logic [10:0] exp_stat(input bit cts, input bit rts, input bit rxb,
                                            input bit txb, input bit wf, input bit rf);
      return {5'b0, cts, rts, rxb, txb, wf, rf};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_op(input logic [1:0] m, input logic [7:0] w, output logic [10:0] r);
      @(negedge clk);
      reg_valid = 1'b1; reg_mode = m; reg_wdata = w;
      @(negedge clk);
      reg_valid = 1'b0;
      r = reg_rdata;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int div);
      bench_rx = b;
      wait_clk(16 * div);
   endtask

   initial begin
      logic [10:0] r;
      logic [7:0]  sent [8];
      int          w;
      void'($urandom(32'd20240611));
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);

      // R11 idle line, R9 rts high, R8 reset status
      check("R11 txd idle after reset", {31'd0, txd}, 32'd1);
      check("R9 rts high after reset", {31'd0, rts_o}, 32'd1);
      reg_op(2'b00, 8'h00, r);
      check("R8 status after reset", {21'd0, r}, {21'd0, exp_stat(1, 1, 0, 0, 0, 0)});
      // R5 empty read returns zero
      reg_op(2'b01, 8'h00, r);
      check("R5 read of empty FIFO", {21'd0, r}, 32'd0);

      // R3 R1 randomized loopback over lengths, parity and two baud selects
      for (int it = 0; it < 20; it++) begin
         int sel, len, pen, pty;
         logic [7:0] d;
         sel = $urandom % 2; len = $urandom % 4; pen = $urandom % 2; pty = $urandom % 2;
         d = 8'($urandom);
         if (it == 0) begin len = 0; d = 8'hFF; end
         if (it == 1) begin len = 3; d = 8'hA5; pen = 1; pty = 1; end
         reg_op(2'b11, {1'b0, 1'(pty), 1'(pen), 2'(len), 3'(sel)}, r);
         reg_op(2'b10, d, r);
         wait_clk(11 * 16 * (1 << sel) + 60);
         reg_op(2'b01, 8'h00, r);
         check($sformatf("R3 loopback it%0d len%0d pen%0d pty%0d", it, len, pen, pty),
               {21'd0, r}, {21'd0, exp_read(0, 0, d, len)});
      end

      // R2 start bit width at baud select 2
      reg_op(2'b11, {1'b0, 1'b0, 1'b0, 2'd3, 3'd2}, r);
      reg_op(2'b10, 8'hFF, r);
      while (txd) @(negedge clk);
      w = 0;
      while (!txd) begin w++; @(negedge clk); end
      check("R2 start bit above 15 ticks", {31'd0, (w > 60)}, 32'd1);
      check("R2 start bit at most 16 ticks", {31'd0, (w <= 64)}, 32'd1);
      wait_clk(11 * 64 + 40);
      reg_op(2'b01, 8'h00, r);
      check("R3 loopback at select 2", {21'd0, r}, 32'h0FF);

      // R10 cts low holds transmission; R4 overfill drops ninth write
      reg_op(2'b11, {1'b0, 1'b0, 1'b0, 2'd3, 3'd0}, r);
      cts_i = 1'b0;
      wait_clk(10);
      for (int i = 0; i < 9; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         if (i < 8) sent[i] = d;
         reg_op(2'b10, d, r);
      end
      wait_clk(300);
      check("R10 txd stays high while cts low", {31'd0, txd}, 32'd1);
      reg_op(2'b00, 8'h00, r);
      check("R8 R4 status: tx full, cts low", {21'd0, r}, {21'd0, exp_stat(0, 1, 0, 0, 1, 0)});
      cts_i = 1'b1;
      wait_clk(10);
      reg_op(2'b00, 8'h00, r);
      check("R8 transmitter busy bit after cts", {21'd0, r & 11'h004}, 32'h004);
      wait_clk(9 * 10 * 16 + 200);
      check("R9 rts low when receive FIFO full", {31'd0, rts_o}, 32'd0);
      reg_op(2'b00, 8'h00, r);
      check("R8 R9 status: rx full", {21'd0, r}, {21'd0, exp_stat(1, 0, 0, 0, 0, 1)});
      for (int i = 0; i < 8; i++) begin
         reg_op(2'b01, 8'h00, r);
         check($sformatf("R5 FIFO order entry %0d", i), {21'd0, r}, {21'd0, exp_read(0, 0, sent[i], 3)});
      end
      reg_op(2'b01, 8'h00, r);
      check("R4 ninth byte dropped", {21'd0, r}, 32'd0);
      check("R9 rts back high", {31'd0, rts_o}, 32'd1);

      // R6 parity error on a bench-driven frame, even parity, 8 bits
      loop_en = 1'b0;
      reg_op(2'b11, {1'b0, 1'b0, 1'b1, 2'd3, 3'd0}, r);
      begin
         logic [7:0] d;
         d = 8'h5A;
         send_bit(1'b0, 1);
         for (int i = 0; i < 8; i++) send_bit(d[i], 1);
         send_bit(~(^d), 1);
         send_bit(1'b1, 1);
         wait_clk(40);
         reg_op(2'b01, 8'h00, r);
         check("R6 bad parity flagged", {21'd0, r}, {21'd0, exp_read(1, 0, d, 3)});
         // good odd-parity frame
         reg_op(2'b11, {1'b0, 1'b1, 1'b1, 2'd3, 3'd0}, r);
         d = 8'hA5;
         send_bit(1'b0, 1);
         for (int i = 0; i < 8; i++) send_bit(d[i], 1);
         send_bit((^d) ^ 1'b1, 1);
         send_bit(1'b1, 1);
         wait_clk(40);
         reg_op(2'b01, 8'h00, r);
         check("R6 correct odd parity clean", {21'd0, r}, {21'd0, exp_read(0, 0, d, 3)});
      end

      // R7 break: line low for a whole frame, no parity
      reg_op(2'b11, {1'b0, 1'b0, 1'b0, 2'd3, 3'd0}, r);
      bench_rx = 1'b0;
      wait_clk(16 * 16);
      bench_rx = 1'b1;
      wait_clk(60);
      reg_op(2'b01, 8'h00, r);
      check("R7 break flagged", {21'd0, r}, 32'h100);
      reg_op(2'b01, 8'h00, r);
      check("R7 single entry per break", {21'd0, r}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule